// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Summary

This block is a bank of general-purpose I/O lines that software controls through a small 32-bit register bus. For each line it holds an output value, a direction bit, a blink enable and an input-polarity bit. Each pin is brought through a two-flop synchroniser and then XORed with its polarity bit. The result is the line's data-in value, which software can read back and which feeds interrupt detection.

Each line can raise two kinds of interrupt. A level interrupt follows the polarity-adjusted input, gated by a level mask. An edge interrupt comes from a sticky cause bit, which records every 0-to-1 change of the polarity-adjusted input and is gated by an edge mask. Software clears a cause bit by writing 0 to it. The gated sources of each run of eight consecutive lines are ORed onto one summary interrupt output, so a 32-line bank drives four outputs. The blink clock comes from outside the block, and the pad buffer is modelled as a value output plus an enable output.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset the direction register reads all ones and all other registers read zero: output, blink, polarity, cause, edge mask and level mask. `pad_oe` is 0 and `irq_grp` is 0.
- R2: Registers are selected by byte address, and each read returns data one cycle after the address is presented. The read/write registers are output (0x00), direction (0x04), blink enable (0x08), polarity (0x0C), edge mask (0x18) and level mask (0x1C), and each reads back what was written. Data-in is at 0x10 and the edge cause is at 0x14.
- R3: Data-in reads as the two-flop synchronised pin value XOR the polarity register.
- R4: `pad_oe` bit i is 1 exactly when direction bit i is 0 (a direction bit of 1 means the line is an input). It follows the direction register one cycle after the register changes.
- R5: When blink enable bit i is 0, `pad_out` bit i equals output bit i. When it is 1, `pad_out` bit i equals output bit i XOR `blink_clk`, with one cycle of register delay.
- R6: A 0-to-1 change of a data-in bit sets its cause bit. A 1-to-0 change does not set it. A change of the polarity bit counts the same way as a change of the pin.
- R7: Writing to the cause offset clears every cause bit written as 0 and leaves every bit written as 1 unchanged. Cause bits never clear in any other way.
- R8: When a new rising data-in event arrives in the same cycle as a clearing write, the cause bit stays set.
- R9: The level source for line i is data-in bit i AND level-mask bit i. A line whose level-mask bit is 0 never raises its summary output through its level.
- R10: A cause bit raises the summary output only while its edge-mask bit is 1. Masking the bit leaves the cause bit itself unchanged.
- R11: Summary output g (bit g of `irq_grp`) is the registered OR of the gated level and edge sources of lines 8g to 8g+7, and of no other lines.
- R12: Writes to the data-in offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register (word aligned) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 32 | Asynchronous pin levels |
| blink_clk | input | 1 | Externally generated blink clock level |
| pad_out | output | 32 | Value driven towards each pad |
| pad_oe | output | 32 | Pad drive enable, 1 = drive |
| irq_grp | output | 4 | Summary interrupt, one per group of eight lines |

## Verification
The hardest case to reach from the ports is a fresh rising event landing in exactly the same clock as a write that clears the same cause bit. The bench counts the synchroniser and edge-detector stages. It raises the pin two edges before the clearing write is sampled, after first setting the cause bit with an earlier pulse, and then expects the bit to read back still set. A second clearing write, issued with no edge present, shows that the clear does work outside that cycle. Polarity-induced edges are also exercised by flipping a polarity bit while the pin stays still.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_OUT   = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_POL   = 3'd3,
    SEL_DIN   = 3'd4,
    SEL_CAUSE = 3'd5,
    SEL_EMASK = 3'd6,
    SEL_LMASK = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_line_sync.sv
module gpio_line_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     din,
  input  logic [W-1:0]     cause,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     dir_q,
  output logic [W-1:0]     blink_q,
  output logic [W-1:0]     pol_q,
  output logic [W-1:0]     emask_q,
  output logic [W-1:0]     lmask_q,
  output logic             wr_cause,
  output logic [W-1:0]     rdata
);
  reg_sel_e sel_e;
  logic [W-1:0] rd_mux;

  assign sel_e    = reg_sel_e'(sel);
  assign wr_cause = wr_en && (sel_e == SEL_CAUSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr_en) begin
      case (sel_e)
        SEL_OUT:   out_q   <= wdata;
        SEL_DIR:   dir_q   <= wdata;
        SEL_BLINK: blink_q <= wdata;
        SEL_POL:   pol_q   <= wdata;
        SEL_EMASK: emask_q <= wdata;
        SEL_LMASK: lmask_q <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel_e)
      SEL_OUT:   rd_mux = out_q;
      SEL_DIR:   rd_mux = dir_q;
      SEL_BLINK: rd_mux = blink_q;
      SEL_POL:   rd_mux = pol_q;
      SEL_DIN:   rd_mux = din;
      SEL_CAUSE: rd_mux = cause;
      SEL_EMASK: rd_mux = emask_q;
      default:   rd_mux = lmask_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W    = 32,
  parameter int GRP  = 8,
  localparam int NGRP = W / GRP
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    din,
  input  logic            wr_cause,
  input  logic [W-1:0]    wdata,
  input  logic [W-1:0]    emask,
  input  logic [W-1:0]    lmask,
  output logic [W-1:0]    rise,
  output logic [W-1:0]    cause_q,
  output logic [NGRP-1:0] irq_q
);
  logic [W-1:0]    din_prev;
  logic [W-1:0]    src;
  logic [NGRP-1:0] grp_any;

  assign rise = din & ~din_prev;
  assign src  = (din & lmask) | (cause_q & emask);

  for (genvar g = 0; g < NGRP; g++) begin : g_group
    assign grp_any[g] = |src[g*GRP +: GRP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      din_prev <= '0;
      cause_q  <= '0;
      irq_q    <= '0;
    end else begin
      din_prev <= din;
      cause_q  <= (wr_cause ? (cause_q & wdata) : cause_q) | rise;
      irq_q    <= grp_any;
    end
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int GRP    = 8,
  localparam int NGRP   = NLINES / GRP,
  localparam int ADDR_W = SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  input  logic              blink_clk,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic [NGRP-1:0]   irq_grp
);
  logic [NLINES-1:0] pin_sync, din;
  logic [NLINES-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
  logic [NLINES-1:0] cause_q, rise;
  logic [SEL_W-1:0]  sel;
  logic              wr_cause;
  logic [1:0]        addr_lsb;

  assign sel      = bus_addr[ADDR_W-1:2];
  assign addr_lsb = bus_addr[1:0];
  assign din      = pin_sync ^ pol_q;

  gpio_line_sync #(.W(NLINES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_ctrl_regs #(.W(NLINES)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && (addr_lsb == 2'b00)), .sel(sel), .wdata(bus_wdata),
    .din(din), .cause(cause_q),
    .out_q(out_q), .dir_q(dir_q), .blink_q(blink_q), .pol_q(pol_q),
    .emask_q(emask_q), .lmask_q(lmask_q),
    .wr_cause(wr_cause), .rdata(bus_rdata)
  );

  gpio_irq_unit #(.W(NLINES), .GRP(GRP)) u_irq (
    .clk(clk), .rst(rst), .din(din),
    .wr_cause(wr_cause), .wdata(bus_wdata),
    .emask(emask_q), .lmask(lmask_q),
    .rise(rise), .cause_q(cause_q), .irq_q(irq_grp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= ~dir_q;
      pad_out <= out_q ^ (blink_q & {NLINES{blink_clk}});
    end
  end
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
  parameter int NLINES = 32,
  parameter int NGRP   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] bus_wdata,
  input logic [NLINES-1:0] dir_q,
  input logic [NLINES-1:0] cause_q,
  input logic [NLINES-1:0] rise,
  input logic              wr_cause,
  input logic [NLINES-1:0] emask_q,
  input logic [NLINES-1:0] lmask_q,
  input logic [NLINES-1:0] pad_oe,
  input logic [NGRP-1:0]   irq_grp
);
  // R4: drive enable is the inverse of the direction register one cycle later
  p_oe_follows_dir_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_oe == ~$past(dir_q)));

  // R6: a rising event always leaves its cause bit set
  p_edge_sets_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((cause_q & $past(rise)) == $past(rise)));

  // R7: without a cause write, no cause bit falls
  p_cause_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_cause |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R7/R8: bits written as 0 with no new event end up clear
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    wr_cause |=> ((cause_q & ~$past(bus_wdata) & ~$past(rise)) == '0));

  // R9/R10: with every mask bit clear, no summary output rises
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ((emask_q == '0) && (lmask_q == '0)) |=> (irq_grp == '0));
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.NLINES(NLINES), .NGRP(NGRP)) u_chk (
  .clk(clk), .rst(rst), .bus_wdata(bus_wdata), .dir_q(dir_q),
  .cause_q(cause_q), .rise(rise), .wr_cause(wr_cause),
  .emask_q(emask_q), .lmask_q(lmask_q), .pad_oe(pad_oe), .irq_grp(irq_grp)
);

// File: tb/gpio_bank_irq_test.sv
module gpio_bank_irq_test;
  localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_BLK = 5'h08,
                         A_POL = 5'h0C, A_DIN = 5'h10, A_CAU = 5'h14,
                         A_EMK = 5'h18, A_LMK = 5'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic        blink_clk = 1'b0;
  logic [31:0] pad_out, pad_oe;
  logic [3:0]  irq_grp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic        rd_req = 1'b0;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  gpio_bank_irq uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .blink_clk(blink_clk), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_grp(irq_grp)
  );

  function automatic void check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // monitor: pops the expectation queued by the read driver
  always @(posedge clk) rd_seen <= rd_req;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check_eq(t, bus_rdata, e);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk);
    pin_in[i] = v;
    wait_n(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    @(negedge clk) rst = 1'b0;

    // R1 reset values
    check_eq("R1 pad_oe", pad_oe, 32'h0);
    check_eq("R1 irq_grp", {28'h0, irq_grp}, 32'h0);
    check_eq("R1 pad_out", pad_out, 32'h0);
    rd(A_OUT, 32'h0, "R1 out");
    rd(A_DIR, 32'hFFFF_FFFF, "R1 dir");
    rd(A_BLK, 32'h0, "R1 blink");
    rd(A_POL, 32'h0, "R1 pol");
    rd(A_DIN, 32'h0, "R1 din");
    rd(A_CAU, 32'h0, "R1 cause");
    rd(A_EMK, 32'h0, "R1 emask");
    rd(A_LMK, 32'h0, "R1 lmask");

    // R2 readback
    wr(A_OUT, 32'hA5A5_0F0F); rd(A_OUT, 32'hA5A5_0F0F, "R2 out");
    wr(A_DIR, 32'h0000_FFFF); rd(A_DIR, 32'h0000_FFFF, "R2 dir");
    wr(A_POL, 32'h1234_5678); rd(A_POL, 32'h1234_5678, "R2 pol");
    wr(A_POL, 32'h0);
    wr(A_EMK, 32'hDEAD_BEEF); rd(A_EMK, 32'hDEAD_BEEF, "R2 emask");
    wr(A_EMK, 32'h0);
    wr(A_LMK, 32'h0F0F_F0F0); rd(A_LMK, 32'h0F0F_F0F0, "R2 lmask");
    wr(A_LMK, 32'h0);
    wr(A_BLK, 32'h0000_0008); rd(A_BLK, 32'h0000_0008, "R2 blink");
    wr(A_BLK, 32'h0);
    wait_n(4);
    wr(A_CAU, 32'h0); wait_n(2);
    rd(A_CAU, 32'h0, "R7 clear all");

    // R12 data-in writes ignored
    wr(A_DIN, 32'hFFFF_FFFF);
    rd(A_DIN, 32'h0, "R12 din write ignored");
    rd(A_OUT, 32'hA5A5_0F0F, "R12 out untouched");

    // R4 drive enable and plain output
    wait_n(2);
    check_eq("R4 pad_oe", pad_oe, 32'hFFFF_0000);
    check_eq("R5 pad_out no blink", pad_out, 32'hA5A5_0F0F);

    // R3 polarity on data-in
    @(negedge clk) pin_in = 32'h0000_00F0;
    wr(A_POL, 32'h0000_0FF0);
    wait_n(4);
    rd(A_DIN, 32'h0000_0F00, "R3 din xor pol");
    wr(A_POL, 32'h0);
    @(negedge clk) pin_in = 32'h0;
    wait_n(5);
    rd(A_DIN, 32'h0, "R3 din plain");
    wr(A_CAU, 32'h0); wait_n(2);

    // R5 blink
    wr(A_BLK, 32'h0000_0008);
    @(negedge clk) blink_clk = 1'b1;
    wait_n(2);
    check_eq("R5 blink high", pad_out, 32'hA5A5_0F07);
    @(negedge clk) blink_clk = 1'b0;
    wait_n(2);
    check_eq("R5 blink low", pad_out, 32'hA5A5_0F0F);

    // R6 edge capture
    pin(1, 1'b1);
    rd(A_CAU, 32'h0000_0002, "R6 rising sets");
    pin(1, 1'b0);
    rd(A_CAU, 32'h0000_0002, "R6 falling ignored");
    wr(A_POL, 32'h0000_0004); wait_n(4);
    rd(A_CAU, 32'h0000_0006, "R6 polarity flip edge");
    wr(A_CAU, 32'h0000_0002);
    rd(A_CAU, 32'h0000_0002, "R7 one keeps zero clears");
    pin(2, 1'b1);
    rd(A_CAU, 32'h0000_0002, "R6 inverted rising pin ignored");
    pin(2, 1'b0);
    rd(A_CAU, 32'h0000_0006, "R6 inverted falling pin sets");
    wr(A_POL, 32'h0); wait_n(4);
    wr(A_CAU, 32'h0);
    rd(A_CAU, 32'h0, "R7 clear");

    // R8 edge beats clear in the same cycle
    pin(5, 1'b1);
    pin(5, 1'b0);
    rd(A_CAU, 32'h0000_0020, "R8 setup");
    @(negedge clk) pin_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk) begin bus_addr = A_CAU; bus_wdata = 32'h0; bus_wr = 1'b1; end
    @(negedge clk) bus_wr = 1'b0;
    rd(A_CAU, 32'h0000_0020, "R8 edge wins");
    wr(A_CAU, 32'h0);
    rd(A_CAU, 32'h0, "R8 later clear works");
    pin(5, 1'b0);

    // R9 / R11 level interrupts and grouping
    wr(A_LMK, 32'h0000_0200);
    pin(9, 1'b1);
    check_eq("R9 level irq", {28'h0, irq_grp}, 32'h2);
    pin(9, 1'b0);
    check_eq("R9 level released", {28'h0, irq_grp}, 32'h0);
    wr(A_LMK, 32'h0);
    pin(9, 1'b1);
    check_eq("R9 level masked", {28'h0, irq_grp}, 32'h0);
    pin(9, 1'b0);
    wr(A_LMK, 32'h8000_0180);
    pin(31, 1'b1);
    check_eq("R11 line31 group3", {28'h0, irq_grp}, 32'h8);
    pin(31, 1'b0);
    pin(7, 1'b1);
    check_eq("R11 line7 group0", {28'h0, irq_grp}, 32'h1);
    pin(7, 1'b0);
    pin(8, 1'b1);
    check_eq("R11 line8 group1", {28'h0, irq_grp}, 32'h2);
    pin(8, 1'b0);
    wr(A_LMK, 32'h0);

    // R10 edge interrupts
    wr(A_CAU, 32'h0);
    wr(A_EMK, 32'h0002_0000);
    pin(17, 1'b1);
    check_eq("R10 edge irq", {28'h0, irq_grp}, 32'h4);
    pin(17, 1'b0);
    check_eq("R10 edge irq sticky", {28'h0, irq_grp}, 32'h4);
    wr(A_EMK, 32'h0); wait_n(2);
    check_eq("R10 edge masked", {28'h0, irq_grp}, 32'h0);
    rd(A_CAU, 32'h0002_0000, "R10 cause kept while masked");
    wr(A_EMK, 32'h0002_0000); wait_n(2);
    check_eq("R10 unmask", {28'h0, irq_grp}, 32'h4);
    wr(A_CAU, 32'h0); wait_n(2);
    check_eq("R10 cleared", {28'h0, irq_grp}, 32'h0);

    wait_n(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule